// File: doc/BRIEF.md
# Programmable 12-bit Interval Timer

This block is a 12-bit up-counter that advances on a basic-clock enable pulse (`tick`). It compares the count with a host-programmed limit and raises a one-cycle interrupt request when a tick brings the count up to that limit. A small control register starts and stops counting and picks how a match is handled. In free-run mode the counter keeps climbing after a match. In limit mode the counter restarts from zero after it shows the limit, so the period is limit+1 ticks.

If the counter rolls past its top value, it latches a wrap flag and freezes. It stays frozen until software clears the flag or issues a one-shot counter clear. The host reaches four word registers through a single-cycle write port and a combinational read port. These are control, wrap flag, count and limit.

Top module: `interval_timer12`

## Requirements
- R1: After synchronous reset the control register, the wrap flag, the count and the limit register all read 0, and `irq` is 0.
- R2: The count advances by exactly one on each cycle with `tick`=1 while the run bit (control bit 0) is 1. It holds its value when the run bit is 0 or `tick` is 0.
- R3: `irq` is high for exactly one cycle, in the cycle the count first shows the limit value after a tick advanced it. A host write that sets the count equal to the limit does not raise `irq`.
- R4: With the match-mode bit (control bit 2) at 0 (free-run), a match leaves the count untouched, and the next tick gives limit+1.
- R5: With control bit 2 at 1 (limit mode), a tick taken while the count equals the limit loads 0. The count sequence is 0..M, then 0 again.
- R6: Writing control with bit 1 set clears the count and the wrap flag in the same edge. Bit 1 is not stored and always reads 0. The run and mode bits take the value of that same write.
- R7: A tick taken at count 4095 loads 0 and sets the wrap flag (bit 0 of address 1). While the flag is set, ticks leave the count at its value.
- R8: Writing address 1 with bit 0 = 0 clears the wrap flag, and counting resumes. Writing bit 0 = 1 leaves the flag unchanged.
- R9: When a host write to the count (address 2) and a counting tick occur in the same cycle, the written value is loaded and the tick is dropped.
- R10: Register addresses are: 0 for control (read as {0, mode, 0, run} in bits 3..0), 1 for the wrap flag in bit 0, 2 for the count, and 3 for the limit. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Basic-clock enable; one count step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt request on a counted match |

## Verification
Two things can fall in the same cycle: a host load of the count and a counting tick. The bench provokes this by asserting `tick` together with a count write at a running timer. It then expects the written value unchanged, with no increment, and expects the following tick to add exactly one. A related check writes the count equal to the limit and confirms that `irq` stays low, so that only counted arrivals interrupt.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    parameter int CNT_W_DEF = 12;

    // register select codes
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_WRAP  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_LIMIT = 2'd3
    } sel_e;

    // control bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_CLR  = 1;
    localparam int CTL_MODE = 2;

    typedef struct packed {
        logic mode;   // 1 = restart on match, 0 = free-run
        logic run;
    } ctrl_t;

    function automatic logic [3:0] ctrl_view(ctrl_t c);
        return {1'b0, c.mode, 1'b0, c.run};
    endfunction

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             wrap_ev,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] limit,
    output logic             wrap_flag,
    output logic             cmd_clr,
    output logic             cmd_load,
    output logic [CNT_W-1:0] reg_rdata
);

    sel_e sel;
    logic wr_ctrl, wr_wrap, wr_limit;

    always_comb begin
        sel      = sel_e'(reg_addr);
        wr_ctrl  = reg_wr && (sel == SEL_CTRL);
        wr_wrap  = reg_wr && (sel == SEL_WRAP);
        wr_limit = reg_wr && (sel == SEL_LIMIT);
        cmd_load = reg_wr && (sel == SEL_COUNT);
        cmd_clr  = wr_ctrl && reg_wdata[CTL_CLR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            limit     <= '0;
            wrap_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run  <= reg_wdata[CTL_RUN];
                ctrl.mode <= reg_wdata[CTL_MODE];
            end
            if (wr_limit)
                limit <= reg_wdata;
            if (wrap_ev)
                wrap_flag <= 1'b1;
            else if (cmd_clr || (wr_wrap && !reg_wdata[0]))
                wrap_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL:  reg_rdata[3:0] = ctrl_view(ctrl);
            SEL_WRAP:  reg_rdata[0]   = wrap_flag;
            SEL_COUNT: reg_rdata      = count;
            SEL_LIMIT: reg_rdata      = limit;
            default:   reg_rdata      = '0;
        endcase
    end

    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (reg_rdata[CTL_CLR] == 1'b0));

    // R7
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_ev |=> wrap_flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && !cmd_clr && !(wr_wrap && !reg_wdata[0])) |=> wrap_flag);

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic             frozen,
    input  logic             cmd_clr,
    input  logic             cmd_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap_ev,
    output logic             irq
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic             step, adv, hit;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        step    = tick && ctrl.run && !frozen;
        adv     = step && !cmd_clr && !cmd_load;
        wrap_ev = adv && (count == TOP);
        nxt     = count;
        if (cmd_clr)
            nxt = '0;
        else if (cmd_load)
            nxt = load_val;
        else if (adv) begin
            if (ctrl.mode && (count == limit))
                nxt = '0;
            else
                nxt = count + 1'b1;
        end
        hit = adv && (nxt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            count <= nxt;
            irq   <= hit;
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !cmd_clr && !cmd_load) |=> $stable(count));

    // R3
    irq_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(adv));

    // R5
    limit_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && ctrl.mode && (count == limit)) |=> (count == '0));

    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_ev |=> (count == '0));

endmodule

// File: rtl/interval_timer12.sv
module interval_timer12
    import itmr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] limit, count;
    logic             wrap_flag, wrap_ev, cmd_clr, cmd_load;

    itmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .count     (count),
        .wrap_ev   (wrap_ev),
        .ctrl      (ctrl),
        .limit     (limit),
        .wrap_flag (wrap_flag),
        .cmd_clr   (cmd_clr),
        .cmd_load  (cmd_load),
        .reg_rdata (reg_rdata)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ctrl     (ctrl),
        .frozen   (wrap_flag),
        .cmd_clr  (cmd_clr),
        .cmd_load (cmd_load),
        .load_val (reg_wdata),
        .limit    (limit),
        .count    (count),
        .wrap_ev  (wrap_ev),
        .irq      (irq)
    );

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && !cmd_clr && !cmd_load) |=> $stable(count));

endmodule

// File: tb/sim_interval_timer12.sv
`timescale 1ns/100ps
module sim_interval_timer12;

    localparam logic [1:0] A_CTRL = 2'd0, A_WRAP = 2'd1, A_CNT = 2'd2, A_LIM = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [11:0] reg_wdata = 12'd0;
    logic [11:0] reg_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    interval_timer12 u0 (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, return just after the posedge
    task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        tick = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [1:0] a, output logic [11:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [11:0] v;
        rd(A_CTRL, v);  chk("R1 ctrl", v, 12'd0);
        rd(A_WRAP, v);  chk("R1 wrap", v, 12'd0);
        rd(A_CNT, v);   chk("R1 count", v, 12'd0);
        rd(A_LIM, v);   chk("R1 limit", v, 12'd0);
        chk("R1 irq", {11'd0, irq}, 12'd0);
    endtask

    task automatic t_free_run();
        logic [11:0] v;
        wr(A_LIM, 12'd5);
        wr(A_CTRL, 12'h003);              // run + clear, free-run
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R2 count after 4 ticks", v, 12'd4);
        chk("R3 no irq before match", {11'd0, irq}, 12'd0);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R4 count at match", v, 12'd5);
        chk("R3 irq at match", {11'd0, irq}, 12'd1);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R4 free-run continues", v, 12'd6);
        chk("R3 irq single cycle", {11'd0, irq}, 12'd0);
        rd(A_CTRL, v); chk("R6 R10 ctrl readback", v, 12'h001);
    endtask

    task automatic t_stop();
        logic [11:0] v;
        wr(A_CTRL, 12'h000);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R2 hold when stopped", v, 12'd6);
        wr(A_CTRL, 12'h001);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R2 hold without tick", v, 12'd6);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R2 resume step", v, 12'd7);
    endtask

    task automatic t_host_match();
        wr(A_CNT, 12'd5);
        chk("R3 host write gives no irq", {11'd0, irq}, 12'd0);
    endtask

    task automatic t_limit_mode();
        logic [11:0] v;
        logic [11:0] exp;
        wr(A_CTRL, 12'h007);              // mode + clear + run
        rd(A_CTRL, v); chk("R10 ctrl mode readback", v, 12'h005);
        exp = 12'd0;
        for (int i = 0; i < 13; i++) begin
            cyc(1'b1, 1'b0, A_CNT, 12'd0);
            exp = (exp == 12'd5) ? 12'd0 : exp + 12'd1;
            rd(A_CNT, v); chk("R5 limit sequence", v, exp);
            chk("R3 R5 irq at limit", {11'd0, irq}, (exp == 12'd5) ? 12'd1 : 12'd0);
        end
    endtask

    task automatic t_priority();
        logic [11:0] v;
        wr(A_CTRL, 12'h001);
        cyc(1'b1, 1'b1, A_CNT, 12'd100);
        rd(A_CNT, v); chk("R9 write beats tick", v, 12'd100);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R9 next tick steps once", v, 12'd101);
    endtask

    task automatic t_wrap();
        logic [11:0] v;
        wr(A_LIM, 12'd10);
        wr(A_CNT, 12'd4094);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R7 reach top", v, 12'd4095);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R7 wrap to zero", v, 12'd0);
        rd(A_WRAP, v); chk("R7 flag set", v, 12'd1);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R7 frozen", v, 12'd0);
        wr(A_WRAP, 12'd1);
        rd(A_WRAP, v); chk("R8 write 1 keeps flag", v, 12'd1);
        wr(A_WRAP, 12'd0);
        rd(A_WRAP, v); chk("R8 write 0 clears flag", v, 12'd0);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R8 counting resumes", v, 12'd1);
    endtask

    task automatic t_clear_wrap();
        logic [11:0] v;
        wr(A_CNT, 12'd4095);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_WRAP, v); chk("R7 flag set again", v, 12'd1);
        wr(A_CNT, 12'd77);
        wr(A_CTRL, 12'h003);
        rd(A_WRAP, v); chk("R6 clear drops flag", v, 12'd0);
        rd(A_CNT, v); chk("R6 clear zeroes count", v, 12'd0);
        rd(A_CTRL, v); chk("R6 clear bit reads 0", v, 12'h001);
    endtask

    task automatic t_limit_top();
        logic [11:0] v;
        wr(A_LIM, 12'd4095);
        wr(A_CTRL, 12'h005);
        wr(A_CNT, 12'd4094);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        chk("R3 irq at limit 4095", {11'd0, irq}, 12'd1);
        cyc(1'b1, 1'b0, A_CNT, 12'd0);
        rd(A_CNT, v); chk("R5 R7 restart from top", v, 12'd0);
        rd(A_WRAP, v); chk("R7 top limit sets flag", v, 12'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_free_run();
        t_stop();
        t_host_match();
        t_limit_mode();
        t_priority();
        t_wrap();
        t_clear_wrap();
        t_limit_top();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule